// File: doc/BRIEF.md
# Two-Way Address Translation Cache with Reference-Bit Replacement

This block turns virtual addresses into physical addresses through a small translation cache with two ways. The cache lives between an address producer and an outside page-table walker. The low bits of the virtual page number pick a set. The remaining high bits are the tag, and the tag is compared against both ways of that set. Each entry holds a tag, a physical page number, two permission bits, and the valid, dirty and reference flags. A lookup gives its answer in the same cycle as the request. The answer is a permitted hit, a miss, or a protection fault.

When a lookup misses, the walker supplies a refill with the page number, the frame number and the permissions. The block picks the victim way itself. It prefers an empty way. Failing that, it picks a way whose reference bit is clear. Every permitted hit sets that entry's reference bit. A global clear input wipes all reference bits periodically, so the bits approximate least-recently-used order. A permitted store marks its entry dirty. If the victim chosen at refill time is valid and dirty, the block raises a write-back indication carrying the evicted frame number.

Top module: `tlb_2way`

## Requirements
- R1: On a permitted hit, `lk_paddr` equals the entry's physical page number in the upper bits, followed by the unchanged low `OFF_W` bits of the virtual address.
- R2: The set index is virtual address bits `[OFF_W +: IDX_W]` and the tag is the bits above it. A lookup hits only when a valid entry of that set holds the same tag; otherwise `lk_miss` is 1. Reset invalidates every entry.
- R3: Permission bit 0 allows reads and bit 1 allows writes. A tag match whose access kind is not allowed gives `lk_fault`=1 with `lk_hit`=0 and `lk_miss`=0.
- R4: A permitted write hit sets the entry's dirty bit. A faulting access changes neither dirty nor reference state.
- R5: Every permitted hit sets the entry's reference bit. `ref_clear` clears all reference bits; a hit in the same cycle still sets its own bit.
- R6: A refill writes tag, frame number and permissions, and marks the entry valid, clean and referenced. The victim is way 0 if it is invalid; otherwise way 1 if it is invalid; otherwise the lowest-numbered way whose reference bit is clear; otherwise way 0.
- R7: In the refill cycle, `wb_valid` is 1 exactly when the victim is valid and dirty, and `wb_ppn` then carries the victim's frame number.
- R8: Entries in different sets are independent; a refill touches only its own set.
- R9: With `lk_valid`=0, the outputs `lk_hit`, `lk_miss` and `lk_fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a store |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Permitted hit |
| lk_miss | output | 1 | No valid matching entry |
| lk_fault | output | 1 | Match but access not permitted |
| lk_paddr | output | PPN_W+OFF_W | Translated physical address |
| fill_valid | input | 1 | Refill strobe from walker |
| fill_vaddr | input | VA_W | Virtual address being refilled (offset ignored) |
| fill_ppn | input | PPN_W | Frame number to install |
| fill_rights | input | 2 | Permissions: bit 0 read, bit 1 write |
| ref_clear | input | 1 | Clear all reference bits |
| wb_valid | output | 1 | Evicted entry is dirty and needs write-back |
| wb_ppn | output | PPN_W | Frame number of the evicted entry |

## Verification
A wrong dirty bit stays hidden until the entry is evicted. It shows up at the ports only as a missing or spurious `wb_valid` in a later refill cycle. For that reason the bench stores to one way, faults on the other, and then forces both of them out. A wrong reference bit shows up as the wrong way being replaced. The first lookup after that refill exposes it as an unexpected miss on the surviving tag. Lookup results are combinational, so a bad tag, permission or frame field appears in the same cycle as the request.

// File: rtl/tlb_2way.sv
module tlb_2way #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 2,
  parameter int PPN_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic                   lk_write,
  input  logic [VA_W-1:0]        lk_vaddr,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic                   lk_fault,
  output logic [PPN_W+OFF_W-1:0] lk_paddr,
  input  logic                   fill_valid,
  input  logic [VA_W-1:0]        fill_vaddr,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic [1:0]             fill_rights,
  input  logic                   ref_clear,
  output logic                   wb_valid,
  output logic [PPN_W-1:0]       wb_ppn
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = VA_W - OFF_W - IDX_W;

  logic [TAG_W-1:0] tag_q    [2][SETS];
  logic [PPN_W-1:0] ppn_q    [2][SETS];
  logic [1:0]       rights_q [2][SETS];
  logic [SETS-1:0]  v_q [2];
  logic [SETS-1:0]  d_q [2];
  logic [SETS-1:0]  r_q [2];

  wire [IDX_W-1:0] set  = lk_vaddr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tag  = lk_vaddr[VA_W-1 -: TAG_W];
  wire [IDX_W-1:0] rset = fill_vaddr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] rtag = fill_vaddr[VA_W-1 -: TAG_W];

  logic [1:0] match;
  logic [1:0] perm;
  for (genvar w = 0; w < 2; w++) begin : g_way
    assign match[w] = v_q[w][set] && (tag_q[w][set] == tag);
    assign perm[w]  = lk_write ? rights_q[w][set][1] : rights_q[w][set][0];
  end

  wire hw  = ~match[0];
  wire any = |match;
  wire ok  = any && perm[hw];

  assign lk_hit   = lk_valid && ok;
  assign lk_fault = lk_valid && any && !ok;
  assign lk_miss  = lk_valid && !any;
  assign lk_paddr = {ppn_q[hw][set], lk_vaddr[OFF_W-1:0]};

  logic vict;
  always_comb begin
    if (!v_q[0][rset])      vict = 1'b0;
    else if (!v_q[1][rset]) vict = 1'b1;
    else if (!r_q[0][rset]) vict = 1'b0;
    else if (!r_q[1][rset]) vict = 1'b1;
    else                    vict = 1'b0;
  end

  assign wb_valid = fill_valid && v_q[vict][rset] && d_q[vict][rset];
  assign wb_ppn   = ppn_q[vict][rset];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 2; w++) begin
        v_q[w] <= '0;
        d_q[w] <= '0;
        r_q[w] <= '0;
      end
    end else begin
      if (ref_clear) begin
        r_q[0] <= '0;
        r_q[1] <= '0;
      end
      if (lk_hit) begin
        r_q[hw][set] <= 1'b1;
        if (lk_write) d_q[hw][set] <= 1'b1;
      end
      if (fill_valid) begin
        tag_q[vict][rset]    <= rtag;
        ppn_q[vict][rset]    <= fill_ppn;
        rights_q[vict][rset] <= fill_rights;
        v_q[vict][rset]      <= 1'b1;
        d_q[vict][rset]      <= 1'b0;
        r_q[vict][rset]      <= 1'b1;
      end
    end
  end

  // R3
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_fault}));

  // R4
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit && lk_write && !fill_valid |=> d_q[$past(hw)][$past(set)]);

  // R4
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault && !fill_valid && !ref_clear |=>
      $stable(d_q[0]) && $stable(d_q[1]) && $stable(r_q[0]) && $stable(r_q[1]));

  // R5
  ref_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clear && !lk_hit && !fill_valid |=> r_q[0] == '0 && r_q[1] == '0);

  // R6
  fill_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> v_q[$past(vict)][$past(rset)] && !d_q[$past(vict)][$past(rset)]
                   && tag_q[$past(vict)][$past(rset)] == $past(rtag));

  // R6
  keep_referenced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && v_q[0][rset] && v_q[1][rset] && (r_q[0][rset] != r_q[1][rset])
      |-> !r_q[vict][rset]);
endmodule

// File: tb/sim_tlb_2way.sv
module sim_tlb_2way;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic        lk_valid = 0, lk_write = 0, fill_valid = 0, ref_clear = 0;
  logic [31:0] lk_vaddr = '0, fill_vaddr = '0;
  logic [19:0] fill_ppn = '0;
  logic [1:0]  fill_rights = '0;
  logic        lk_hit, lk_miss, lk_fault, wb_valid;
  logic [31:0] lk_paddr;
  logic [19:0] wb_ppn;

  tlb_2way u0 (.clk, .rst_n, .lk_valid, .lk_write, .lk_vaddr, .lk_hit, .lk_miss,
               .lk_fault, .lk_paddr, .fill_valid, .fill_vaddr, .fill_ppn,
               .fill_rights, .ref_clear, .wb_valid, .wb_ppn);

  typedef struct {
    logic h, m, f, wb;
    logic [31:0] pa;
    logic [19:0] wbp;
    string req;
  } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] va(int t, int i, int o);
    logic [31:0] r;
    r = {t[17:0], i[1:0], o[11:0]};
    return r;
  endfunction

  task automatic look(logic [31:0] a, logic wr, logic h, logic m, logic f,
                      logic [31:0] pa, string req);
    exp_t e;
    @(negedge clk);
    lk_valid = 1; lk_write = wr; lk_vaddr = a; fill_valid = 0; ref_clear = 0;
    e.h = h; e.m = m; e.f = f; e.wb = 0; e.pa = pa; e.wbp = '0; e.req = req;
    q.push_back(e);
  endtask

  task automatic fill(logic [31:0] a, logic [19:0] p, logic [1:0] rt, logic wb,
                      logic [19:0] wbp, string req);
    exp_t e;
    @(negedge clk);
    lk_valid = 0; lk_write = 0; fill_valid = 1; fill_vaddr = a; fill_ppn = p;
    fill_rights = rt; ref_clear = 0;
    e.h = 0; e.m = 0; e.f = 0; e.wb = wb; e.pa = '0; e.wbp = wbp; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(logic clr, string req);
    exp_t e;
    @(negedge clk);
    lk_valid = 0; lk_write = 0; fill_valid = 0; ref_clear = clr;
    e.h = 0; e.m = 0; e.f = 0; e.wb = 0; e.pa = '0; e.wbp = '0; e.req = req;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        e = q.pop_front();
        tests++;
        if (lk_hit !== e.h || lk_miss !== e.m || lk_fault !== e.f || wb_valid !== e.wb
            || (e.h && lk_paddr !== e.pa) || (e.wb && wb_ppn !== e.wbp)) begin
          fails++;
          $display("FAIL %s: got hit=%b miss=%b fault=%b pa=%h wb=%b wbp=%h, exp hit=%b miss=%b fault=%b pa=%h wb=%b wbp=%h",
                   e.req, lk_hit, lk_miss, lk_fault, lk_paddr, wb_valid, wb_ppn,
                   e.h, e.m, e.f, e.pa, e.wb, e.wbp);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(va(5,1,'h123), 0, 0, 1, 0, '0, "R2 reset invalid");
    fill(va(5,1,0), 20'hAAAAA, 2'b11, 0, '0, "R6 empty way0");
    look(va(5,1,'h123), 0, 1, 0, 0, 32'hAAAAA123, "R1 hit paddr");
    fill(va(6,1,0), 20'hBBBBB, 2'b01, 0, '0, "R6 empty way1");
    look(va(6,1,'h7ff), 0, 1, 0, 0, 32'hBBBBB7FF, "R1 way1 paddr");
    look(va(6,1,0), 1, 0, 0, 1, '0, "R3 write denied");
    look(va(5,1,'h004), 1, 1, 0, 0, 32'hAAAAA004, "R4 write hit");
    idle(1, "R9 idle outputs");
    look(va(5,1,'h008), 0, 1, 0, 0, 32'hAAAAA008, "R5 hit after clear");
    fill(va(7,1,0), 20'hCCCCC, 2'b11, 0, '0, "R4 R6 unreferenced clean victim");
    look(va(6,1,0), 0, 0, 1, 0, '0, "R6 way1 replaced");
    look(va(7,1,'h010), 0, 1, 0, 0, 32'hCCCCC010, "R6 new entry");
    look(va(5,1,'h020), 0, 1, 0, 0, 32'hAAAAA020, "R6 referenced kept");
    idle(1, "R5 clear");
    look(va(7,1,0), 0, 1, 0, 0, 32'hCCCCC000, "R5 reference way1");
    fill(va(8,1,0), 20'hDDDDD, 2'b11, 1, 20'hAAAAA, "R7 dirty victim");
    look(va(5,1,0), 0, 0, 1, 0, '0, "R7 evicted");
    look(va(8,1,'habc), 0, 1, 0, 0, 32'hDDDDDABC, "R7 installed");
    fill(va(9,1,0), 20'hEEEEE, 2'b11, 0, '0, "R6 both referenced picks way0");
    look(va(8,1,0), 0, 0, 1, 0, '0, "R6 way0 replaced");
    look(va(7,1,'h001), 0, 1, 0, 0, 32'hCCCCC001, "R6 way1 survives");
    fill(va(5,2,0), 20'h0F0F0, 2'b10, 0, '0, "R8 other set fill");
    look(va(5,2,0), 0, 0, 0, 1, '0, "R3 read denied");
    look(va(5,2,'h001), 1, 1, 0, 0, 32'h0F0F0001, "R8 R3 write allowed");
    look(va(5,0,0), 0, 0, 1, 0, '0, "R8 set0 untouched");
    look(va(9,1,'h002), 0, 1, 0, 0, 32'hEEEEE002, "R8 set1 untouched");
    idle(0, "R9 final idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule